// File: doc/BRIEF.md
# Scatter-Gather DMA Channel Sequencer

This block is the control engine for one DMA channel that runs peripheral scatter-gather work. It uses two descriptors of four words each, held in memory at fixed base addresses: a primary and an alternate. Each descriptor holds a source end pointer, a destination end pointer, a configuration word and one spare word. The primary descriptor only ever reprograms the alternate one. A granted peripheral request starts a primary cycle. That cycle copies a four-word task entry from a task list in memory into the alternate slot. It then writes the primary configuration word back with its cycle-control field cleared, which marks it invalid. With no arbitration step in between, the engine then fetches and executes the alternate descriptor.

When a chained alternate cycle ends, the engine returns to arbitration and waits for the next granted request to start another primary cycle. The run ends in one of two ways. If the alternate descriptor selects a basic cycle, `done` pulses once. If a fetched descriptor is invalid, a sticky error flag is raised and the engine halts until `err_clr` is applied. Memory is a word-wide synchronous port with a read latency of one cycle. Every transfer moves a 32-bit word, and transfer i of an N-transfer cycle uses the address end_pointer - (N-1-i)*4.

Top module: `sg_dma_seq`

## Requirements
- R1: After reset, `arb_req`, `mem_req`, `done` and `err` are all low.
- R2: `arb_req` is high only while the engine is idle and `periph_req` is high. A cycle starts only on a cycle where both `arb_req` and `arb_grant` are high, so a grant without a request causes no memory access.
- R3: A primary cycle reads descriptor words at PRI_BASE+0 (source end), +4 (destination end) and +8 (configuration). It then performs exactly four word copies, which fill the four alternate descriptor words at ALT_BASE+0..+12 from the task entry.
- R4: A primary configuration word is accepted only when bits [31:24] = 8'hAA, bits [17:14] = 4'b0010 and bits [2:0] = 3'b110. Any other value sets `err`, and no memory write is made.
- R5: After its four copies, the primary cycle writes the primary configuration word back to PRI_BASE+8 with bits [2:0] cleared and every other bit unchanged. Bits [23:18], bit 3 and bits [13:4] of the primary word have no effect on sequencing.
- R6: The configuration write-back of R5 is followed directly by the alternate descriptor fetch, and `arb_req` stays low between the write-back and the first alternate transfer.
- R7: An alternate cycle performs n_minus_1+1 word copies, where n_minus_1 is bits [13:4] of its configuration word. Copy i reads src_end-(n_minus_1-i)*4 and writes dst_end-(n_minus_1-i)*4. No other word is written.
- R8: An alternate cycle whose bits [2:0] are neither 3'b000 nor 3'b001 chains. When it finishes, the engine returns to arbitration and makes no memory access until it is granted again.
- R9: An alternate cycle with bits [2:0] = 3'b001 is a basic cycle. After its last copy, `done` is high for exactly one clock and the engine returns to arbitration.
- R10: An alternate descriptor with bits [2:0] = 3'b000 sets `err`. No alternate transfer is made and `done` does not pulse.
- R11: `err` stays set, and `arb_req` stays low, until `err_clr` is high for one clock. After that the engine is idle again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| periph_req | input | 1 | Peripheral transfer request |
| arb_req | output | 1 | Request to the channel arbiter |
| arb_grant | input | 1 | Grant from the channel arbiter |
| mem_req | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory write enable (read when low) |
| mem_addr | output | AW | Byte address of the word accessed |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid the cycle after a read strobe |
| done | output | 1 | One-clock pulse when a basic alternate cycle ends |
| err | output | 1 | Sticky invalid-descriptor flag |
| err_clr | input | 1 | Clears `err` and releases the halted engine |

## Verification
Some properties are checked by assertions on every cycle. `done` never lasts longer than one clock. A write-back is always followed directly by the alternate fetch, with `arb_req` low. A primary cycle never starts without a granted request. The transfer index stays within its count. `err` stays set until it is cleared. Other behaviour can only be shown by the bench scenarios. These cover memory contents after chains of random length with random counts, data and don't-care bits, and the exact value written back to the primary descriptor. They also cover the engine staying quiet while ungranted between chained cycles, and the error paths for a corrupted primary field and an invalid alternate descriptor.

// File: rtl/sg_dma_pkg.sv
// Package: shared types and encodings for the scatter-gather sequencer.
// Assumes 32-bit configuration words with the field layout given below.
package sg_dma_pkg;

    // Sequencer states
    typedef enum logic [3:0] {
        ST_ARB  = 4'd0,   // idle, presenting request to arbiter
        ST_F0   = 4'd1,   // read descriptor word 0
        ST_F1   = 4'd2,   // read word 1, capture word 0
        ST_F2   = 4'd3,   // read word 2, capture word 1
        ST_CHK  = 4'd4,   // capture configuration word and decide
        ST_RD   = 4'd5,   // read one source word
        ST_WR   = 4'd6,   // write that word to its destination
        ST_INV  = 4'd7,   // write back primary configuration as invalid
        ST_HALT = 4'd8    // stopped on an invalid descriptor
    } sg_state_e;

    // Configuration word layout
    typedef struct packed {
        logic [1:0] dst_step;
        logic [1:0] dst_width;
        logic [1:0] src_step;
        logic [1:0] src_width;
        logic [2:0] wr_prot;
        logic [2:0] rd_prot;
        logic [3:0] count_pow;
        logic [9:0] last_idx;
        logic       spare;
        logic [2:0] mode;
    } sg_cfg_t;

    localparam logic [2:0] MODE_INVALID = 3'b000;
    localparam logic [2:0] MODE_BASIC   = 3'b001;
    localparam logic [2:0] MODE_PRI_SG  = 3'b110;
    localparam logic [1:0] CODE_WORD    = 2'b10;
    localparam logic [3:0] PRI_POW      = 4'b0010;
    localparam int         IDX_W        = 10;

endpackage

// File: rtl/sg_cfg_decode.sv
// Module: sg_cfg_decode
// Splits a configuration word into the fields the sequencer needs and
// classifies it as an acceptable primary or as an invalid/basic alternate.
// Assumes the word is stable while the sequencer samples the outputs.
module sg_cfg_decode
    import sg_dma_pkg::*;
(
    input  logic [31:0]      cfg_word,
    output logic [IDX_W-1:0] last_idx,
    output logic             pri_ok,
    output logic             alt_invalid,
    output logic             alt_basic
);
    sg_cfg_t f;
    logic    unused_cfg_bits;

    // Purpose: view the raw word as fields.
    assign f = sg_cfg_t'(cfg_word);

    // Purpose: protection bits and spare bit take no part in sequencing.
    assign unused_cfg_bits = ^{f.wr_prot, f.rd_prot, f.spare};

    // Purpose: classify the word.
    always_comb begin
        last_idx    = f.last_idx;
        pri_ok      = (f.dst_step == CODE_WORD) && (f.dst_width == CODE_WORD) &&
                      (f.src_step == CODE_WORD) && (f.src_width == CODE_WORD) &&
                      (f.count_pow == PRI_POW)  && (f.mode == MODE_PRI_SG);
        alt_invalid = (f.mode == MODE_INVALID);
        alt_basic   = (f.mode == MODE_BASIC);
    end
endmodule

// File: rtl/sg_addr_gen.sv
// Module: sg_addr_gen
// Forms the byte address of one word transfer counted back from an end
// pointer: end - (last - cur) * word_bytes. Assumes cur <= last.
module sg_addr_gen #(
    parameter int AW         = 32,
    parameter int CW         = 10,
    parameter int WORD_BYTES = 4
) (
    input  logic [AW-1:0] end_ptr,
    input  logic [CW-1:0] last_idx,
    input  logic [CW-1:0] cur_idx,
    output logic [AW-1:0] addr
);
    localparam int SHIFT = $clog2(WORD_BYTES);

    logic [CW-1:0] remain;

    // Purpose: words still to go after this one, scaled to bytes.
    always_comb begin
        remain = last_idx - cur_idx;
        addr   = end_ptr - (AW'(remain) << SHIFT);
    end
endmodule

// File: rtl/sg_dma_seq.sv
// Module: sg_dma_seq (top)
// Single-channel peripheral scatter-gather sequencer. A granted request runs
// a primary cycle that copies four words into the alternate descriptor,
// invalidates the primary and falls straight into the alternate cycle.
// Assumes a memory that answers a read in the following cycle and accepts a
// write at the edge it is presented, with no wait states.
module sg_dma_seq
    import sg_dma_pkg::*;
#(
    parameter int            AW       = 32,
    parameter logic [AW-1:0] PRI_BASE = '0,
    parameter logic [AW-1:0] ALT_BASE = AW'(16)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          periph_req,
    output logic          arb_req,
    input  logic          arb_grant,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [31:0]   mem_wdata,
    input  logic [31:0]   mem_rdata,
    output logic          done,
    output logic          err,
    input  logic          err_clr
);
    localparam int            CW       = IDX_W;
    localparam logic [CW-1:0] PRI_LAST = CW'((1 << int'(PRI_POW)) - 1);
    localparam logic [AW-1:0] OFS_SRC  = AW'(0);
    localparam logic [AW-1:0] OFS_DST  = AW'(4);
    localparam logic [AW-1:0] OFS_CFG  = AW'(8);
    localparam int            NPTR     = 2;

    sg_state_e     state;
    logic          alt_ph;
    logic          basic_q;
    logic [AW-1:0] end_q [NPTR];
    logic [31:0]   cfg_q;
    logic [CW-1:0] idx;
    logic [CW-1:0] last_q;
    logic          done_q;
    logic          err_q;

    logic [CW-1:0] dec_last;
    logic          pri_ok, alt_invalid, alt_basic;
    logic          err_set;
    logic [AW-1:0] base;
    logic [AW-1:0] xaddr [NPTR];

    // Purpose: decode the configuration word as it arrives from memory.
    sg_cfg_decode u_dec (
        .cfg_word    (mem_rdata),
        .last_idx    (dec_last),
        .pri_ok      (pri_ok),
        .alt_invalid (alt_invalid),
        .alt_basic   (alt_basic)
    );

    // Purpose: one address generator per pointer (0 = source, 1 = destination).
    for (genvar g = 0; g < NPTR; g++) begin : g_addr
        sg_addr_gen #(.AW(AW), .CW(CW), .WORD_BYTES(4)) u_ag (
            .end_ptr  (end_q[g]),
            .last_idx (last_q),
            .cur_idx  (idx),
            .addr     (xaddr[g])
        );
    end

    // Purpose: descriptor base of the current phase and the error condition.
    assign base    = alt_ph ? ALT_BASE : PRI_BASE;
    assign err_set = (state == ST_CHK) && (alt_ph ? alt_invalid : !pri_ok);

    // Purpose: main sequencing state machine.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_ARB;
            alt_ph  <= 1'b0;
            basic_q <= 1'b0;
            end_q   <= '{default: '0};
            cfg_q   <= '0;
            idx     <= '0;
            last_q  <= '0;
        end else begin
            case (state)
                ST_ARB: begin
                    if (periph_req && arb_grant) begin
                        state  <= ST_F0;
                        alt_ph <= 1'b0;
                    end
                end
                ST_F0: state <= ST_F1;
                ST_F1: begin
                    end_q[0] <= mem_rdata[AW-1:0];
                    state    <= ST_F2;
                end
                ST_F2: begin
                    end_q[1] <= mem_rdata[AW-1:0];
                    state    <= ST_CHK;
                end
                ST_CHK: begin
                    cfg_q <= mem_rdata;
                    idx   <= '0;
                    if (err_set) begin
                        state <= ST_HALT;
                    end else begin
                        last_q  <= alt_ph ? dec_last : PRI_LAST;
                        basic_q <= alt_ph && alt_basic;
                        state   <= ST_RD;
                    end
                end
                ST_RD: state <= ST_WR;
                ST_WR: begin
                    if (idx == last_q) begin
                        if (!alt_ph) begin
                            state <= ST_INV;
                        end else begin
                            state  <= ST_ARB;
                            alt_ph <= 1'b0;
                        end
                    end else begin
                        idx   <= idx + 1'b1;
                        state <= ST_RD;
                    end
                end
                ST_INV: begin
                    alt_ph <= 1'b1;
                    state  <= ST_F0;
                end
                ST_HALT: begin
                    if (err_clr) state <= ST_ARB;
                end
                default: state <= ST_ARB;
            endcase
        end
    end

    // Purpose: one-clock completion pulse and sticky error flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            done_q <= (state == ST_WR) && alt_ph && basic_q && (idx == last_q);
            if (err_set)      err_q <= 1'b1;
            else if (err_clr) err_q <= 1'b0;
        end
    end

    // Purpose: drive the memory port from the current state.
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        case (state)
            ST_F0: begin mem_req = 1'b1; mem_addr = base + OFS_SRC; end
            ST_F1: begin mem_req = 1'b1; mem_addr = base + OFS_DST; end
            ST_F2: begin mem_req = 1'b1; mem_addr = base + OFS_CFG; end
            ST_RD: begin mem_req = 1'b1; mem_addr = xaddr[0]; end
            ST_WR: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = xaddr[1];
                mem_wdata = mem_rdata;
            end
            ST_INV: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = PRI_BASE + OFS_CFG;
                mem_wdata = cfg_q & ~32'h7;
            end
            default: ;
        endcase
    end

    // Purpose: arbiter request and status outputs.
    assign arb_req = (state == ST_ARB) && periph_req;
    assign done    = done_q;
    assign err     = err_q;

    // R9: completion pulse never lasts two clocks.
    assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R6: write-back is followed directly by the alternate fetch, unarbitrated.
    assert_no_rearb_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_INV) |=> (mem_req && !mem_we && mem_addr == ALT_BASE && !arb_req));

    // R2: a primary fetch begins only after a granted request.
    assert_start_granted_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_F0 && !alt_ph) |-> $past(arb_req && arb_grant));

    // R7: transfer index never passes its last value.
    assert_idx_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RD || state == ST_WR) |-> (idx <= last_q));

    // R11: error stays set until cleared.
    assert_err_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (err && !err_clr) |=> err);

    // R4: a rejected primary leads to a halt with no memory access.
    assert_bad_pri_halts_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CHK && !alt_ph && !pri_ok) |=> (!mem_req && err));

    // R3: the invalidating write follows exactly four primary copies.
    assert_pri_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_INV) |-> (last_q == PRI_LAST && $past(idx) == PRI_LAST));
endmodule

// File: tb/sg_dma_seq_test.sv
module sg_dma_seq_test;
    localparam logic [31:0] PRI = 32'h0;
    localparam logic [31:0] ALT = 32'h10;
    localparam int WD_LIMIT = 150000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic periph_req = 1'b0, arb_grant = 1'b0, err_clr = 1'b0;
    logic arb_req, mem_req, mem_we, done, err;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;

    logic [31:0] mem [0:255];
    logic [31:0] exp_mem [0:255];
    logic        h_we = 1'b0, h_clr = 1'b0;
    logic [31:0] h_addr = '0, h_data = '0;

    int checks = 0, errors = 0;
    int mem_cnt = 0, wr_cnt = 0, inv_cnt = 0, done_cnt = 0, done_long = 0, viol = 0;
    logic [31:0] inv_last = '0;
    logic since_inv = 1'b0, prev_done = 1'b0;
    int cyc = 0;

    always #5 clk = ~clk;

    sg_dma_seq #(.AW(32), .PRI_BASE(PRI), .ALT_BASE(ALT)) uut (
        .clk(clk), .rst_n(rst_n), .periph_req(periph_req), .arb_req(arb_req),
        .arb_grant(arb_grant), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .done(done), .err(err), .err_clr(err_clr)
    );

    // Memory model: synchronous read with one cycle of latency, plus host port.
    always @(posedge clk) begin
        if (h_clr) begin
            for (int i = 0; i < 256; i++) mem[i] <= '0;
        end else if (mem_req && mem_we) begin
            mem[mem_addr[9:2]] <= mem_wdata;
        end else if (h_we) begin
            mem[h_addr[9:2]] <= h_data;
        end
        if (mem_req && !mem_we) mem_rdata <= mem[mem_addr[9:2]];
    end

    // Monitor, sampled away from the active edge.
    always @(negedge clk) begin
        if (mem_req) mem_cnt++;
        if (mem_req && mem_we) wr_cnt++;
        if (done) done_cnt++;
        if (done && prev_done) done_long++;
        prev_done = done;
        if (mem_req && mem_we && mem_addr == PRI + 32'd8 && !since_inv) begin
            inv_cnt++;
            inv_last = mem_wdata;
            since_inv = 1'b1;
        end else if (since_inv) begin
            if (err) since_inv = 1'b0;
            else if (arb_req) begin viol++; since_inv = 1'b0; end
            else if (mem_req && mem_we) since_inv = 1'b0;
        end
    end

    // Watchdog: an expired run counts as one failed check.
    always @(posedge clk) begin
        cyc++;
        if (cyc > WD_LIMIT) begin
            $display("FAIL watchdog: actual=%0d cycles expected<=%0d", cyc, WD_LIMIT);
            $display("Result: errors=%0d of %0d checks", errors + 1, checks + 1);
            $finish;
        end
    end

    function automatic logic [31:0] xfer_addr(logic [31:0] end_ptr, int last, int i);
        return end_ptr - 32'((last - i) * 4);
    endfunction

    function automatic logic [31:0] good_pri_cfg(logic [31:0] r);
        return 32'hAA00_0000 | (32'd2 << 14) | 32'd6 | (r & 32'h00FC_3FF8);
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, expv);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic hwrite(input logic [31:0] a, input logic [31:0] d);
        h_we = 1'b1; h_addr = a; h_data = d;
        @(negedge clk);
        h_we = 1'b0;
        exp_mem[a[9:2]] = d;
    endtask

    task automatic clear_all();
        h_clr = 1'b1;
        @(negedge clk);
        h_clr = 1'b0;
        for (int i = 0; i < 256; i++) exp_mem[i] = '0;
    endtask

    task automatic wait_arb();
        while (!arb_req) @(negedge clk);
    endtask

    task automatic grant_pulse();
        arb_grant = 1'b1;
        @(negedge clk);
        arb_grant = 1'b0;
    endtask

    task automatic program_pri(input logic [31:0] task_addr, input logic [31:0] cfg);
        hwrite(PRI + 32'd0, task_addr + 32'd12);
        hwrite(PRI + 32'd4, ALT + 32'd12);
        hwrite(PRI + 32'd8, cfg);
    endtask

    task automatic pulse_clr();
        err_clr = 1'b1;
        @(negedge clk);
        err_clr = 1'b0;
    endtask

    // Build one task entry with its source data; returns the entry address.
    task automatic build_task(input int k, input int last, input logic [2:0] mode,
                              output logic [31:0] ta, output logic [31:0] e [4]);
        logic [31:0] src_base, dst_base;
        ta       = 32'h100 + 32'(16 * k);
        src_base = 32'h200 + 32'(32 * k);
        dst_base = 32'h300 + 32'(32 * k);
        for (int j = 0; j <= last; j++) hwrite(src_base + 32'(4 * j), $urandom);
        e[0] = src_base + 32'(4 * last);
        e[1] = dst_base + 32'(4 * last);
        e[2] = ($urandom & 32'hFFFF_C008) | (32'(last) << 4) | {29'd0, mode};
        e[3] = $urandom;
        for (int w = 0; w < 4; w++) hwrite(ta + 32'(4 * w), e[w]);
    endtask

    // Expected effect of one primary plus alternate cycle.
    task automatic model_cycle(input logic [31:0] e [4], input logic [31:0] pcfg,
                               input bit run_alt);
        for (int w = 0; w < 4; w++) exp_mem[(ALT[9:2]) + 8'(w)] = e[w];
        exp_mem[PRI[9:2] + 8'd2] = pcfg & ~32'h7;
        if (run_alt) begin
            for (int i = 0; i <= int'(e[2][13:4]); i++)
                exp_mem[xfer_addr(e[1], int'(e[2][13:4]), i) >> 2] =
                    exp_mem[xfer_addr(e[0], int'(e[2][13:4]), i) >> 2];
        end
    endtask

    task automatic compare_mem(input string ctx);
        int bad_alt = 0, bad_oth = 0;
        logic [31:0] a_act = '0, a_exp = '0, o_act = '0, o_exp = '0;
        for (int i = 0; i < 256; i++) begin
            if (mem[i] !== exp_mem[i]) begin
                if (i >= int'(ALT[9:2]) && i < int'(ALT[9:2]) + 4) begin
                    if (bad_alt == 0) begin a_act = mem[i]; a_exp = exp_mem[i]; end
                    bad_alt++;
                end else begin
                    if (bad_oth == 0) begin o_act = mem[i]; o_exp = exp_mem[i]; end
                    bad_oth++;
                end
            end
        end
        check(bad_alt == 0, {"R3 alternate descriptor ", ctx}, a_act, a_exp);
        check(bad_oth == 0, {"R7 memory image ", ctx}, o_act, o_exp);
    endtask

    initial begin
        int unsigned seed_init;
        seed_init = $urandom(32'd20240611);
        tick(3);
        rst_n = 1'b1;
        @(negedge clk);
        clear_all();

        // R1: reset state
        check(!arb_req && !mem_req, "R1 idle outputs", {30'd0, arb_req, mem_req}, 32'd0);
        check(!done && !err, "R1 done/err", {30'd0, done, err}, 32'd0);

        // R2: grant without request does nothing; request raises arb_req
        begin
            int m0;
            m0 = mem_cnt;
            arb_grant = 1'b1;
            tick(10);
            arb_grant = 1'b0;
            check(mem_cnt == m0, "R2 grant without request", 32'(mem_cnt - m0), 32'd0);
            check(!arb_req, "R2 arb_req without request", {31'd0, arb_req}, 32'd0);
            periph_req = 1'b1;
            @(negedge clk);
            check(arb_req, "R2 arb_req follows request", {31'd0, arb_req}, 32'd1);
            check(mem_cnt == m0, "R2 no access before grant", 32'(mem_cnt - m0), 32'd0);
            periph_req = 1'b0;
            @(negedge clk);
        end

        // Random scatter-gather chains
        for (int s = 0; s < 8; s++) begin
            int kmax;
            int d0;
            clear_all();
            kmax = 1 + int'($urandom % 3);
            periph_req = 1'b1;
            for (int k = 0; k < kmax; k++) begin
                logic [31:0] ta, pcfg;
                logic [31:0] e [4];
                logic [2:0] mode;
                int last, i0;
                last = (s == 0 && k == 0) ? 0 : int'($urandom % 7);
                mode = (k == kmax - 1) ? 3'b001 : 3'(2 + ($urandom % 6));
                build_task(k, last, mode, ta, e);
                wait_arb();
                pcfg = good_pri_cfg($urandom);
                program_pri(ta, pcfg);
                i0 = inv_cnt;
                d0 = done_cnt;
                grant_pulse();
                while (inv_cnt == i0) @(negedge clk);
                check(inv_last == (pcfg & ~32'h7), "R5 write-back value", inv_last,
                      pcfg & ~32'h7);
                model_cycle(e, pcfg, 1'b1);
                if (k == kmax - 1) begin
                    while (done_cnt == d0) @(negedge clk);
                    @(negedge clk);
                    check(done_cnt == d0 + 1, "R9 single done pulse", 32'(done_cnt - d0), 32'd1);
                    check(arb_req, "R9 back to arbitration", {31'd0, arb_req}, 32'd1);
                end else begin
                    int m0;
                    wait_arb();
                    m0 = mem_cnt;
                    tick(5);
                    check(mem_cnt == m0 && arb_req, "R8 waits for grant after chain",
                          32'(mem_cnt - m0), 32'd0);
                    check(done_cnt == d0, "R8 no done on chained cycle",
                          32'(done_cnt - d0), 32'd0);
                end
            end
            periph_req = 1'b0;
            tick(3);
            compare_mem($sformatf("scenario %0d", s));
            check(done_long == 0, "R9 done width", 32'(done_long), 32'd0);
            check(viol == 0, "R6 no arbitration after write-back", 32'(viol), 32'd0);
            check(!err, "R4 valid primaries accepted", {31'd0, err}, 32'd0);
        end

        // R4 / R11: corrupted primary configuration
        for (int t = 0; t < 3; t++) begin
            logic [31:0] bad;
            int pick, pos, w0, d0;
            clear_all();
            pick = int'($urandom % 15);
            pos  = (pick < 8) ? 24 + pick : (pick < 12) ? 14 + pick - 8 : pick - 12;
            bad  = good_pri_cfg($urandom) ^ (32'd1 << pos);
            periph_req = 1'b1;
            wait_arb();
            program_pri(32'h100, bad);
            w0 = wr_cnt;
            d0 = done_cnt;
            grant_pulse();
            tick(8);
            check(err, "R4 bad primary flagged", {31'd0, err}, 32'd1);
            check(wr_cnt == w0, "R4 no write on bad primary", 32'(wr_cnt - w0), 32'd0);
            check(done_cnt == d0, "R4 no done on bad primary", 32'(done_cnt - d0), 32'd0);
            tick(10);
            check(err && !arb_req, "R11 halted and sticky", {30'd0, err, arb_req}, 32'd2);
            pulse_clr();
            check(!err && arb_req, "R11 cleared and idle", {30'd0, err, arb_req}, 32'd1);
            periph_req = 1'b0;
            @(negedge clk);
        end

        // R10: invalid alternate descriptor
        begin
            logic [31:0] ta, pcfg;
            logic [31:0] e [4];
            int i0, d0, n;
            clear_all();
            build_task(0, 3, 3'b000, ta, e);
            periph_req = 1'b1;
            wait_arb();
            pcfg = good_pri_cfg($urandom);
            program_pri(ta, pcfg);
            i0 = inv_cnt;
            d0 = done_cnt;
            grant_pulse();
            n = 0;
            while (!err && n < 100) begin @(negedge clk); n++; end
            check(err, "R10 invalid alternate flagged", {31'd0, err}, 32'd1);
            check(inv_cnt == i0 + 1, "R10 primary ran first", 32'(inv_cnt - i0), 32'd1);
            check(done_cnt == d0, "R10 no done", 32'(done_cnt - d0), 32'd0);
            model_cycle(e, pcfg, 1'b0);
            compare_mem("invalid alternate");
            pulse_clr();
            check(!err, "R11 clear after invalid alternate", {31'd0, err}, 32'd0);
            periph_req = 1'b0;
            @(negedge clk);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule